// File: doc/BRIEF.md
# Wired Interrupt Aggregator

The block gathers a bank of interrupt source lines into one wired interrupt request for a parent controller. Each source is synchronised into the clock domain and latched into a pending-cause register. A single detection mode applies to every source of the instance: level-high or rising-edge. A pending cause drives the output only while its mask bit is clear.

Software reaches four registers over a single-cycle register port. It reads pending causes and clears them by writing zeros. It can inject causes to re-trigger an interrupt, mask individual sources, and select the detection mode. The control register also holds a flag that turns off the message-signalled path, so that only the wired output is used. That flag is brought out on a port for the message logic, which is outside this block.

Top module: `wired_irq_ctrl`

## Requirements
- R1: After reset the mask reads all ones, the cause and control registers read zero, and both `irq_o` and `msg_off_o` are low.
- R2: The register offsets are cause 0x00, set-cause 0x08, mask 0x10 and control 0x28. A read of set-cause or of any other offset returns zero, and a write to any other offset changes no register.
- R3: Control bit 3 selects rising-edge detection (1) or level-high detection (0) for all sources. Control bit 5 drives `msg_off_o`. All other control bits read as zero.
- R4: A write to cause clears each bit written 0 and keeps each bit written 1.
- R5: A write to set-cause sets each cause bit written 1. Bits written 0 have no effect.
- R6: `irq_o` is the OR of cause AND NOT mask, registered, so it follows a cause or mask change by one cycle.
- R7: A mask bit of 1 keeps its source off `irq_o` but still lets the source be recorded in cause. Only a write to mask changes the mask.
- R8: In edge mode, a 0-to-1 transition of a synchronised source sets its cause bit once. A source that stays high does not set the bit again after software clears it.
- R9: In level mode, the cause bit is set on every cycle the synchronised source is high.
- R10: If a hardware set and a software clear of the same bit fall in the same cycle, the set wins. In level mode, clearing the bit while its source is still high leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Interrupt source lines, asynchronous |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 6 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of a read strobe |
| irq_o | output | 1 | Wired interrupt to the parent controller |
| msg_off_o | output | 1 | Message-signalled path disabled flag |

## Verification
Every cycle, the assertions check the following. A clear write removes the zero-written bits when no hardware event is pending. An inject write sets its bits. A hardware set always lands in cause, whatever the bus does. The mask moves only on a mask write. `irq_o` tracks the unmasked causes one cycle late. In edge mode, a source never produces two set events back to back. Only the bench scenarios can show the end-to-end behaviour: the synchroniser latency, a level source that outlives a clear, an edge source that stays cleared while held high, decoding of unmapped offsets, and the readback of the control fields. A random register sequence against a reference model covers the interplay of clear, inject and mask.

// File: rtl/wic_pkg.sv
package wic_pkg;
  localparam int unsigned ADDR_W = 6;
  localparam logic [ADDR_W-1:0] OFF_CAUSE = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_SET   = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_MASK  = 6'h10;
  localparam logic [ADDR_W-1:0] OFF_CTRL  = 6'h28;
  localparam int unsigned CTRL_EDGE_BIT = 3;
  localparam int unsigned CTRL_MSG_BIT  = 5;

  typedef enum logic [1:0] {
    ACC_CAUSE = 2'd0,
    ACC_SET   = 2'd1,
    ACC_MASK  = 2'd2,
    ACC_CTRL  = 2'd3
  } acc_sel_e;
endpackage

// File: rtl/wic_src_detect.sv
module wic_src_detect #(
  parameter int unsigned N_SRC       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic             edge_mode_i,
  output logic [N_SRC-1:0] hw_set_o
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  for (genvar k = 0; k < N_SRC; k++) begin : g_src
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sync_q <= '0;
        prev_q <= 1'b0;
      end else begin
        if (SYNC_STAGES > 1) sync_q <= {sync_q[SYNC_STAGES-2:0], src_i[k]};
        else                 sync_q <= src_i[k];
        prev_q <= sync_q[LAST];
      end
    end

    assign hw_set_o[k] = edge_mode_i ? (sync_q[LAST] & ~prev_q) : sync_q[LAST];
  end

  // edge mode never yields two set events in a row for one source
  p_edge_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode_i && $past(edge_mode_i)) |-> ((hw_set_o & $past(hw_set_o)) == '0));
endmodule

// File: rtl/wic_regs.sv
module wic_regs
  import wic_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_SRC-1:0]  hw_set_i,
  output logic [N_SRC-1:0]  cause_o,
  output logic [N_SRC-1:0]  mask_o,
  output logic              edge_mode_o,
  output logic              msg_off_o
);
  logic [N_SRC-1:0] cause_q, cause_d, mask_q, wbits;
  logic             edge_q, msg_q, hit;
  acc_sel_e         sel;

  assign wbits = wdata_i[N_SRC-1:0];

  always_comb begin
    hit = 1'b1;
    sel = ACC_CAUSE;
    unique case (addr_i)
      OFF_CAUSE: sel = ACC_CAUSE;
      OFF_SET:   sel = ACC_SET;
      OFF_MASK:  sel = ACC_MASK;
      OFF_CTRL:  sel = ACC_CTRL;
      default:   hit = 1'b0;
    endcase
  end

  logic wr_cause, wr_set, wr_mask, wr_ctrl;
  assign wr_cause = req_i && we_i && hit && (sel == ACC_CAUSE);
  assign wr_set   = req_i && we_i && hit && (sel == ACC_SET);
  assign wr_mask  = req_i && we_i && hit && (sel == ACC_MASK);
  assign wr_ctrl  = req_i && we_i && hit && (sel == ACC_CTRL);

  // hardware set applied last so it beats a same-cycle clear
  always_comb begin
    cause_d = cause_q;
    if (wr_cause) cause_d = cause_d & wbits;
    if (wr_set)   cause_d = cause_d | wbits;
    cause_d = cause_d | hw_set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= '0;
      mask_q  <= '1;
      edge_q  <= 1'b0;
      msg_q   <= 1'b0;
    end else begin
      cause_q <= cause_d;
      if (wr_mask) mask_q <= wbits;
      if (wr_ctrl) begin
        edge_q <= wdata_i[CTRL_EDGE_BIT];
        msg_q  <= wdata_i[CTRL_MSG_BIT];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i && hit) begin
      unique case (sel)
        ACC_CAUSE: rdata_o = DATA_W'(cause_q);
        ACC_MASK:  rdata_o = DATA_W'(mask_q);
        ACC_CTRL: begin
          rdata_o[CTRL_EDGE_BIT] = edge_q;
          rdata_o[CTRL_MSG_BIT]  = msg_q;
        end
        default:   rdata_o = '0;
      endcase
    end
  end

  assign cause_o     = cause_q;
  assign mask_o      = mask_q;
  assign edge_mode_o = edge_q;
  assign msg_off_o   = msg_q;

  p_clear_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cause && hw_set_i == '0) |=> ((cause_q & ~$past(wbits)) == '0));
  p_inject_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_set |=> ((cause_q & $past(wbits)) == $past(wbits)));
  p_hw_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_set_i != '0) |=> ((cause_q & $past(hw_set_i)) == $past(hw_set_i)));
  p_mask_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_mask |=> $stable(mask_q));
endmodule

// File: rtl/wic_out.sv
module wic_out #(
  parameter int unsigned N_SRC = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] cause_i,
  input  logic [N_SRC-1:0] mask_i,
  output logic             irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(cause_i & ~mask_i);
  end

  assign irq_o = irq_q;

  p_irq_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cause_i & ~mask_i) != '0) |=> irq_o);
  p_irq_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cause_i & ~mask_i) == '0) |=> !irq_o);
endmodule

// File: rtl/wired_irq_ctrl.sv
module wired_irq_ctrl
  import wic_pkg::*;
#(
  parameter int unsigned N_SRC       = 32,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              msg_off_o
);
  logic [N_SRC-1:0] hw_set, cause, mask;
  logic             edge_mode;

  wic_src_detect #(.N_SRC(N_SRC), .SYNC_STAGES(SYNC_STAGES)) u_detect (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .src_i       (src_i),
    .edge_mode_i (edge_mode),
    .hw_set_o    (hw_set)
  );

  wic_regs #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .we_i        (we_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .rdata_o     (rdata_o),
    .hw_set_i    (hw_set),
    .cause_o     (cause),
    .mask_o      (mask),
    .edge_mode_o (edge_mode),
    .msg_off_o   (msg_off_o)
  );

  wic_out #(.N_SRC(N_SRC)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cause_i (cause),
    .mask_i  (mask),
    .irq_o   (irq_o)
  );
endmodule

// File: tb/wired_irq_ctrl_tb_top.sv
module wired_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] A_CAUSE = 6'h00, A_SET = 6'h08, A_MASK = 6'h10, A_CTRL = 6'h28;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic [31:0] src_i = '0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [5:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o, msg_off_o;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  wired_irq_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o),
    .msg_off_o(msg_off_o)
  );

  function automatic logic exp_irq(logic [31:0] c, logic [31:0] m);
    return |(c & ~m);
  endfunction

  function automatic logic [31:0] model_write(logic [5:0] a, logic [31:0] d,
                                              logic [31:0] cur_c);
    if (a == A_CAUSE) return cur_c & d;
    if (a == A_SET)   return cur_c | d;
    return cur_c;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #1 d = rdata_o;
    req_i = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v, mc, mm, mk;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    idle(2);

    // R1 reset state
    rd(A_MASK, v);  chk("R1 mask", v, 32'hFFFF_FFFF);
    rd(A_CAUSE, v); chk("R1 cause", v, 32'h0);
    rd(A_CTRL, v);  chk("R1 ctrl", v, 32'h0);
    chk("R1 irq_o", {31'h0, irq_o}, 32'h0);
    chk("R1 msg_off_o", {31'h0, msg_off_o}, 32'h0);

    // R2 decode: set-cause and unmapped reads are zero, unmapped writes ignored
    wr(A_SET, 32'h0000_0001);
    rd(A_SET, v);   chk("R2 set-cause read", v, 32'h0);
    rd(6'h04, v);   chk("R2 unmapped read", v, 32'h0);
    wr(6'h04, 32'h0);
    wr(6'h14, 32'h0);
    wr(6'h2C, 32'hFFFF_FFFF);
    rd(A_CAUSE, v); chk("R2 unmapped write cause", v, 32'h1);
    rd(A_MASK, v);  chk("R2 unmapped write mask", v, 32'hFFFF_FFFF);
    rd(A_CTRL, v);  chk("R2 unmapped write ctrl", v, 32'h0);
    wr(A_CAUSE, 32'h0);

    // R3 control fields
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, v);  chk("R3 ctrl readback", v, 32'h28);
    chk("R3 msg_off_o", {31'h0, msg_off_o}, 32'h1);
    wr(A_CTRL, 32'h0);
    chk("R3 msg_off_o clear", {31'h0, msg_off_o}, 32'h0);

    // R9/R10/R6 level mode
    wr(A_MASK, ~32'h10);
    src_i[4] = 1'b1;
    idle(5);
    rd(A_CAUSE, v); chk("R9 level capture", v, 32'h10);
    chk("R6 irq on unmasked cause", {31'h0, irq_o}, 32'h1);
    wr(A_CAUSE, 32'h0);
    idle(2);
    rd(A_CAUSE, v); chk("R10 clear while level high", v, 32'h10);
    src_i[4] = 1'b0;
    idle(5);
    wr(A_CAUSE, 32'h0);
    rd(A_CAUSE, v); chk("R4 clear after source low", v, 32'h0);
    idle(1);
    chk("R6 irq drops", {31'h0, irq_o}, 32'h0);

    // R7 masked source still recorded, no irq
    src_i[9] = 1'b1;
    idle(5);
    rd(A_CAUSE, v); chk("R7 masked cause recorded", v, 32'h200);
    chk("R7 masked irq", {31'h0, irq_o}, 32'h0);
    src_i[9] = 1'b0;
    idle(5);
    wr(A_CAUSE, 32'h0);
    wr(A_MASK, ~32'h80);

    // R8 edge mode
    wr(A_CTRL, 32'h08);
    src_i[7] = 1'b1;
    idle(5);
    rd(A_CAUSE, v); chk("R8 edge capture", v, 32'h80);
    chk("R8 edge irq", {31'h0, irq_o}, 32'h1);
    wr(A_CAUSE, 32'h0);
    idle(5);
    rd(A_CAUSE, v); chk("R8 held high stays clear", v, 32'h0);
    src_i[7] = 1'b0;
    idle(4);
    src_i[7] = 1'b1;
    idle(5);
    rd(A_CAUSE, v); chk("R8 second edge", v, 32'h80);
    src_i[7] = 1'b0;
    idle(4);
    wr(A_CAUSE, 32'h0);

    // R4/R5 directed
    wr(A_SET, 32'h0000_00F0);
    rd(A_CAUSE, v); chk("R5 inject", v, 32'hF0);
    wr(A_SET, 32'h0);
    rd(A_CAUSE, v); chk("R5 zero inject no effect", v, 32'hF0);
    wr(A_CAUSE, 32'h0000_0030);
    rd(A_CAUSE, v); chk("R4 keep ones clear zeros", v, 32'h30);
    wr(A_CAUSE, 32'h0);

    // random register traffic against model, sources idle
    mc = '0; mm = ~32'h80; mk = 32'h08;
    for (int i = 0; i < 300; i++) begin
      logic [5:0]  a;
      logic [31:0] d;
      int          op;
      op = int'($urandom_range(0, 4));
      d  = $urandom;
      case (op)
        0: a = A_CAUSE;
        1: a = A_SET;
        2: a = A_MASK;
        3: a = A_CTRL;
        default: a = 6'h18;
      endcase
      wr(a, d);
      mc = model_write(a, d, mc);
      if (a == A_MASK) mm = d;
      if (a == A_CTRL) mk = d & 32'h28;
      rd(A_CAUSE, v); chk("R4 R5 random cause", v, mc);
      rd(A_MASK, v);  chk("R7 random mask", v, mm);
      chk("R6 random irq", {31'h0, irq_o}, {31'h0, exp_irq(mc, mm)});
      if (op >= 3) begin
        rd(A_CTRL, v); chk("R3 random ctrl", v, mk);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule